// File: doc/BRIEF.md
# Two-Phase Dual-Rail Transition Codec

This block is a matched transmitter and receiver for a narrow word channel in which values move as wire toggles rather than as levels. Each bit of the word has its own pair of rails. To send a 0 the transmitter flips the zero-rail of that pair, and to send a 1 it flips the one-rail. The direction of the flip carries no meaning. The receiver delivers the word and then flips a single acknowledge wire. The transmitter will not send again until it has seen that wire flip.

Both ends keep a registered copy of the last rail levels they observed. A change relative to that copy is an event. The whole codec runs on one shared clock that samples the rails, so it remains an ordinary synchronous design. The rails and the acknowledge wire leave and re-enter the top module as ports. The surrounding logic, or a bench, joins them as a loopback and can disturb them along the way.

Top module: `tr2_codec`

## Requirements
- R1: While synchronous reset is high and on the first cycle after it, every transmit rail, the acknowledge output and all stored rail copies are 0. The transmitter is ready, no word is presented and the error flag is low.
- R2: When a word is accepted (`snd_valid` and `snd_ready` high at a clock edge), exactly one rail of each pair flips on that edge. Bit value 1 flips the one-rail and bit value 0 flips the zero-rail. No pair ever has both rails flip on the same edge.
- R3: A rising and a falling rail edge are equal events. Sending the same word twice returns the rails to their earlier levels, and both transfers decode to that word.
- R4: `snd_ready` is low from the edge that accepts a word until the edge at which the transmitter samples an acknowledge level different from the last one it stored. It is high again after that edge, three cycles after acceptance when the consumer is ready.
- R5: The receiver compares the incoming rails with its stored copy. When every pair shows exactly one changed rail, `rcv_valid` is high after the next edge, and bit i of `rcv_data` is 1 if the one-rail of pair i changed.
- R6: While `rcv_valid` is high and `rcv_ready` is low, `rcv_valid`, `rcv_data` and `ack_out` stay unchanged.
- R7: `ack_out` flips exactly once per delivered word, on the edge where `rcv_valid` and `rcv_ready` are both high, and at no other time.
- R8: If any pair shows both rails changed in one sample while the receiver is listening, `proto_err` is high for exactly one cycle and no word is presented. The stored copy takes the sampled levels, and `ack_out` does not flip. A later normal transfer decodes correctly.
- R9: If only some pairs have changed, the receiver presents nothing and keeps waiting. The word is delivered once the remaining pairs have changed.
- R10: Over a long stream with random gaps at the sender and random stalls at the receiver, every accepted word is delivered exactly once, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| snd_valid | input | 1 | Word offered to the transmitter |
| snd_ready | output | 1 | Transmitter can accept a word |
| snd_data | input | NPAIR | Word to send, one bit per rail pair |
| tx_zero | output | NPAIR | Transmit zero-rails |
| tx_one | output | NPAIR | Transmit one-rails |
| ack_in | input | 1 | Acknowledge wire as seen by the transmitter |
| rx_zero | input | NPAIR | Zero-rails as seen by the receiver |
| rx_one | input | NPAIR | One-rails as seen by the receiver |
| ack_out | output | 1 | Acknowledge wire driven by the receiver |
| rcv_valid | output | 1 | Decoded word present |
| rcv_ready | input | 1 | Consumer takes the decoded word |
| rcv_data | output | NPAIR | Decoded word |
| proto_err | output | 1 | One-cycle pulse on a pair with both rails changed |

## Verification
With a direct loopback, the rails flip on the accepting edge. The decoded word is present one edge later, the acknowledge flips on the edge that consumes it, and `snd_ready` returns on the edge after that. The bench drives on the falling edge and samples each of these results on the falling edge that follows the edge responsible for it, so the rails are checked one half cycle after acceptance and the readiness three and a half cycles after. The error pulse and partial-arrival cases are produced by XOR masks on the loopback. They are checked one sample after the mask changes, and on the following sample to confirm the error pulse lasts a single cycle. During the random stream a queue model is compared at every falling edge, and each consume is checked against the oldest accepted word.

// File: rtl/tr2_pkg.sv
package tr2_pkg;

    // Event seen on one rail pair: {one_changed, zero_changed}
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_ZERO = 2'b01,
        EV_ONE  = 2'b10,
        EV_BAD  = 2'b11
    } lane_ev_e;

    typedef struct packed {
        logic one;
        logic zero;
    } rail_t;

    typedef enum logic {
        RX_LISTEN = 1'b0,
        RX_HOLD   = 1'b1
    } rx_state_e;

    function automatic lane_ev_e classify(input rail_t now_lv, input rail_t old_lv);
        logic ch0;
        logic ch1;
        ch0 = now_lv.zero ^ old_lv.zero;
        ch1 = now_lv.one ^ old_lv.one;
        unique case ({ch1, ch0})
            2'b00:   return EV_NONE;
            2'b01:   return EV_ZERO;
            2'b10:   return EV_ONE;
            default: return EV_BAD;
        endcase
    endfunction

    function automatic rail_t flip_for(input rail_t lv, input logic b);
        rail_t r;
        r = lv;
        if (b) r.one  = ~lv.one;
        else   r.zero = ~lv.zero;
        return r;
    endfunction

endpackage

// File: rtl/tr2_tx_lane.sv
module tr2_tx_lane
    import tr2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  bit_in,
    output rail_t level
);
    rail_t lv_q;

    always_ff @(posedge clk) begin
        if (rst)       lv_q <= '0;
        else if (fire) lv_q <= flip_for(lv_q, bit_in);
    end

    assign level = lv_q;
endmodule

// File: rtl/tr2_tx.sv
module tr2_tx
    import tr2_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic [NPAIR-1:0] snd_data,
    input  logic             ack_in,
    output logic [NPAIR-1:0] tx_zero,
    output logic [NPAIR-1:0] tx_one
);
    logic busy_q;
    logic ack_seen_q;
    logic fire;
    logic ack_event;

    assign fire      = snd_valid & ~busy_q;
    assign ack_event = ack_in ^ ack_seen_q;
    assign snd_ready = ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            ack_seen_q <= 1'b0;
        end else begin
            ack_seen_q <= ack_in;
            if (fire)                        busy_q <= 1'b1;
            else if (busy_q && ack_event)    busy_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_lane
        rail_t lv;
        tr2_tx_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .fire   (fire),
            .bit_in (snd_data[i]),
            .level  (lv)
        );
        assign tx_zero[i] = lv.zero;
        assign tx_one[i]  = lv.one;
    end
endmodule

// File: rtl/tr2_rx_lane.sv
module tr2_rx_lane
    import tr2_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  logic     in_zero,
    input  logic     in_one,
    output lane_ev_e ev
);
    rail_t seen_q;
    rail_t cur;

    assign cur.zero = in_zero;
    assign cur.one  = in_one;
    assign ev       = classify(cur, seen_q);

    always_ff @(posedge clk) begin
        if (rst)         seen_q <= '0;
        else if (commit) seen_q <= cur;
    end
endmodule

// File: rtl/tr2_rx.sv
module tr2_rx
    import tr2_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPAIR-1:0] rx_zero,
    input  logic [NPAIR-1:0] rx_one,
    output logic             ack_out,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic [NPAIR-1:0] rcv_data,
    output logic             proto_err
);
    rx_state_e        st_q;
    logic             ack_q;
    logic             err_q;
    logic [NPAIR-1:0] data_q;
    logic [NPAIR-1:0] lane_done;
    logic [NPAIR-1:0] lane_bad;
    logic [NPAIR-1:0] lane_bit;
    logic             listening;
    logic             all_done;
    logic             any_bad;
    logic             commit;

    assign listening = (st_q == RX_LISTEN);
    assign all_done  = &lane_done;
    assign any_bad   = |lane_bad;
    assign commit    = listening & (any_bad | all_done);

    for (genvar i = 0; i < NPAIR; i++) begin : g_lane
        lane_ev_e ev;
        tr2_rx_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .commit  (commit),
            .in_zero (rx_zero[i]),
            .in_one  (rx_one[i]),
            .ev      (ev)
        );
        assign lane_done[i] = (ev == EV_ZERO) || (ev == EV_ONE);
        assign lane_bad[i]  = (ev == EV_BAD);
        assign lane_bit[i]  = (ev == EV_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_LISTEN;
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            err_q <= listening & any_bad;
            unique case (st_q)
                RX_LISTEN: begin
                    if (!any_bad && all_done) begin
                        data_q <= lane_bit;
                        st_q   <= RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (rcv_ready) begin
                        ack_q <= ~ack_q;
                        st_q  <= RX_LISTEN;
                    end
                end
                default: st_q <= RX_LISTEN;
            endcase
        end
    end

    assign ack_out   = ack_q;
    assign rcv_valid = (st_q == RX_HOLD);
    assign rcv_data  = data_q;
    assign proto_err = err_q;
endmodule

// File: rtl/tr2_codec.sv
module tr2_codec
    import tr2_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic [NPAIR-1:0] snd_data,
    output logic [NPAIR-1:0] tx_zero,
    output logic [NPAIR-1:0] tx_one,
    input  logic             ack_in,
    input  logic [NPAIR-1:0] rx_zero,
    input  logic [NPAIR-1:0] rx_one,
    output logic             ack_out,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic [NPAIR-1:0] rcv_data,
    output logic             proto_err
);
    tr2_tx #(.NPAIR(NPAIR)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .snd_valid (snd_valid),
        .snd_ready (snd_ready),
        .snd_data  (snd_data),
        .ack_in    (ack_in),
        .tx_zero   (tx_zero),
        .tx_one    (tx_one)
    );

    tr2_rx #(.NPAIR(NPAIR)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_zero   (rx_zero),
        .rx_one    (rx_one),
        .ack_out   (ack_out),
        .rcv_valid (rcv_valid),
        .rcv_ready (rcv_ready),
        .rcv_data  (rcv_data),
        .proto_err (proto_err)
    );
endmodule

// File: rtl/tr2_check.sv
module tr2_check #(
    parameter int NPAIR = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             snd_valid,
    input logic             snd_ready,
    input logic [NPAIR-1:0] tx_zero,
    input logic [NPAIR-1:0] tx_one,
    input logic             ack_out,
    input logic             rcv_valid,
    input logic             rcv_ready,
    input logic [NPAIR-1:0] rcv_data,
    input logic             proto_err
);
    // R1: one cycle after reset everything is at rest
    a_r1_reset_rest: assert property (@(posedge clk)
        rst |=> (tx_zero == '0 && tx_one == '0 && !ack_out && !rcv_valid && !proto_err));

    // R2: never both rails of one pair on the same edge
    a_r2_one_rail_per_pair: assert property (@(posedge clk) disable iff (rst)
        ((tx_zero ^ $past(tx_zero)) & (tx_one ^ $past(tx_one))) == '0);

    // R2: an accepted word flips one rail in every pair
    a_r2_all_pairs_flip: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && snd_ready) |=>
            $countones((tx_zero ^ $past(tx_zero)) | (tx_one ^ $past(tx_one))) == NPAIR);

    // R4: no rail activity while the transmitter waits
    a_r4_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        !snd_ready |=> ($stable(tx_zero) && $stable(tx_one)));

    // R4: acceptance drops readiness
    a_r4_busy_after_send: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && snd_ready) |=> !snd_ready);

    // R6: a stalled word holds
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && !rcv_ready) |=> (rcv_valid && $stable(rcv_data) && $stable(ack_out)));

    // R7: acknowledge flips on consume
    a_r7_ack_on_consume: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && rcv_ready) |=> (ack_out != $past(ack_out)));

    // R7: acknowledge is quiet otherwise
    a_r7_ack_quiet: assert property (@(posedge clk) disable iff (rst)
        !(rcv_valid && rcv_ready) |=> $stable(ack_out));

    // R8: an error pulse never comes with a word
    a_r8_err_no_word: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !rcv_valid);
endmodule

bind tr2_codec tr2_check #(.NPAIR(NPAIR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .snd_valid (snd_valid),
    .snd_ready (snd_ready),
    .tx_zero   (tx_zero),
    .tx_one    (tx_one),
    .ack_out   (ack_out),
    .rcv_valid (rcv_valid),
    .rcv_ready (rcv_ready),
    .rcv_data  (rcv_data),
    .proto_err (proto_err)
);

// File: tb/sim_tr2_codec.sv
module sim_tr2_codec;
    localparam int NP     = 4;
    localparam int PERIOD = 10;
    localparam int NWORDS = 300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          snd_valid = 1'b0;
    logic          snd_ready;
    logic [NP-1:0] snd_data = '0;
    logic [NP-1:0] tx_zero, tx_one, rx_zero, rx_one;
    logic [NP-1:0] inj0 = '0, inj1 = '0;
    logic          ack_out;
    logic          rcv_valid;
    logic          rcv_ready = 1'b0;
    logic [NP-1:0] rcv_data;
    logic          proto_err;

    int n_chk  = 0;
    int n_fail = 0;
    logic [NP-1:0] sb[$];

    assign rx_zero = tx_zero ^ inj0;
    assign rx_one  = tx_one ^ inj1;

    tr2_codec #(.NPAIR(NP)) u0 (
        .clk(clk), .rst(rst),
        .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_data(snd_data),
        .tx_zero(tx_zero), .tx_one(tx_one), .ack_in(ack_out),
        .rx_zero(rx_zero), .rx_one(rx_one), .ack_out(ack_out),
        .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_data(rcv_data),
        .proto_err(proto_err)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Full handshake with a ready consumer, checking each due cycle
    task automatic send_word(input logic [NP-1:0] d);
        logic [NP-1:0] z0, z1;
        logic ak;
        z0 = tx_zero; z1 = tx_one; ak = ack_out;
        rcv_ready = 1'b1;
        snd_valid = 1'b1; snd_data = d;
        tick();
        snd_valid = 1'b0;
        chk(tx_one == (z1 ^ d), "R2 one-rails", int'(tx_one), int'(z1 ^ d));
        chk(tx_zero == (z0 ^ ~d), "R2 zero-rails", int'(tx_zero), int'(z0 ^ ~d));
        chk(!snd_ready, "R4 busy after accept", snd_ready, 0);
        tick();
        chk(rcv_valid && rcv_data == d, "R5 word decoded", int'(rcv_data), int'(d));
        tick();
        chk(!rcv_valid && ack_out == ~ak, "R7 ack flipped", ack_out, int'(~ak));
        chk(!snd_ready, "R4 still busy", snd_ready, 0);
        tick();
        chk(snd_ready, "R4 ready again", snd_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [NP-1:0] z0, z1, hd;
        logic ak;
        repeat (3) tick();
        chk(tx_zero == '0 && tx_one == '0 && !ack_out, "R1 rails at rest",
            int'({tx_one, tx_zero}), 0);
        chk(snd_ready && !rcv_valid && !proto_err, "R1 flags",
            int'({snd_ready, rcv_valid, proto_err}), 4);
        rst = 1'b0;
        tick();
        chk(snd_ready && !rcv_valid && !ack_out, "R1 after release",
            int'({snd_ready, rcv_valid, ack_out}), 4);

        send_word(4'b1010);
        send_word(4'b0110);
        // R3: repeat the same word, rails return, same decode
        z0 = tx_zero; z1 = tx_one;
        send_word(4'b0110);
        send_word(4'b0110);
        chk(tx_zero == z0 && tx_one == z1, "R3 rails returned",
            int'({tx_one, tx_zero}), int'({z1, z0}));
        send_word(4'b0000);
        send_word(4'b1111);

        // R6: stalled consumer
        rcv_ready = 1'b0; ak = ack_out;
        snd_valid = 1'b1; snd_data = 4'b1001;
        tick(); snd_valid = 1'b0;
        tick();
        hd = rcv_data;
        chk(rcv_valid && hd == 4'b1001, "R6 word present", int'(hd), 9);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(rcv_valid && rcv_data == hd && ack_out == ak, "R6 held",
                int'({rcv_valid, rcv_data}), int'({1'b1, hd}));
        end
        chk(!snd_ready, "R4 busy during stall", snd_ready, 0);
        rcv_ready = 1'b1;
        tick();
        chk(!rcv_valid && ack_out == ~ak, "R7 ack after stall", ack_out, int'(~ak));
        tick();
        chk(snd_ready, "R4 ready after stall", snd_ready, 1);

        // R8: both rails of pair 0 change together
        ak = ack_out;
        inj0[0] = 1'b1; inj1[0] = 1'b1;
        tick();
        chk(proto_err && !rcv_valid, "R8 error pulse", int'({proto_err, rcv_valid}), 2);
        tick();
        chk(!proto_err && !rcv_valid && ack_out == ak, "R8 single cycle",
            int'({proto_err, rcv_valid, ack_out}), int'({2'b00, ak}));
        send_word(4'b0101);

        // R9: partial arrival, pair 1 one-rail first
        inj1[1] = ~inj1[1];
        tick();
        for (int k = 0; k < 3; k++) begin
            chk(!rcv_valid && !proto_err, "R9 waits on partial",
                int'({rcv_valid, proto_err}), 0);
            tick();
        end
        inj0[0] = ~inj0[0]; inj0[2] = ~inj0[2]; inj0[3] = ~inj0[3];
        tick();
        chk(rcv_valid && rcv_data == 4'b0010, "R9 completed word", int'(rcv_data), 2);
        tick();
        tick();
        chk(snd_ready && !rcv_valid, "R9 sender unaffected",
            int'({snd_ready, rcv_valid}), 2);
        send_word(4'b1100);

        // R10: random stream with a queue model compared each cycle
        begin
            int sent = 0, got = 0, cyc = 0;
            bit acc = 0;
            logic [NP-1:0] pz, po;
            pz = tx_zero; po = tx_one;
            while (got < NWORDS && cyc < 40000) begin
                tick();
                cyc++;
                chk(((tx_zero ^ pz) & (tx_one ^ po)) == '0, "R2 no double flip",
                    int'((tx_zero ^ pz) & (tx_one ^ po)), 0);
                pz = tx_zero; po = tx_one;
                chk(rcv_valid == 1'b0 || sb.size() > 0, "R10 no phantom word",
                    sb.size(), 1);
                if (acc) begin snd_valid = 1'b0; acc = 0; end
                if (!snd_valid && sent < NWORDS && ($urandom % 3) != 0) begin
                    snd_valid = 1'b1;
                    snd_data  = NP'($urandom);
                end
                rcv_ready = (($urandom % 4) != 0);
                if (snd_valid && snd_ready) begin
                    sb.push_back(snd_data);
                    sent++;
                    acc = 1;
                end
                if (rcv_valid && rcv_ready && sb.size() > 0) begin
                    logic [NP-1:0] e;
                    e = sb.pop_front();
                    chk(rcv_data == e, "R10 order", int'(rcv_data), int'(e));
                    got++;
                end
            end
            chk(got == NWORDS && sb.size() == 0, "R10 all delivered", got, NWORDS);
        end
        snd_valid = 1'b0;
        repeat (4) tick();
        summary();
    end
endmodule